// File: doc/BRIEF.md
# Packed String Compare Unit

This block compares two 128-bit operands that each carry a short packed character string, either sixteen 8-bit characters or eight 16-bit characters. Every element of the first operand is compared with every element of the second operand. The resulting all-pairs matrix is then reduced in one of four ways, and the reduction yields a result mask with one bit per element of the second operand.

The four reductions have these uses:
- Position-wise equality reads the diagonal of the matrix.
- Set membership ORs each column of the matrix.
- Range classification tests the second operand against low/high bound pairs held in the first operand.
- Substring search ANDs the diagonals that start at each position of the second operand.

A zero element ends the string in either operand. The block also reports the position of the lowest set mask bit, with a flag for the case where no bit is set. A request is presented with a one-cycle valid strobe. The result appears on registered outputs one clock later and stays there until the next request.

Top module: `pkd_str_cmp`

## Requirements
- R1: With `word_mode_i`=0, element k of an operand is bits [8k+7:8k], and there are 16 elements. With `word_mode_i`=1, element k is bits [16k+15:16k], and there are 8 elements. In word mode, mask bits 15..8 are always zero. Mask bit j always refers to element j of `src_b_i`, so bit 0 is its lowest element.
- R2: `mode_i`=0 (position equality). Mask bit j is set when element j of A equals element j of B, and both elements are live.
- R3: `mode_i`=1 (set membership). Mask bit j is set when element j of B is live and equals at least one live element of A.
- R4: `mode_i`=2 (ranges). A holds bound pairs at elements (2k, 2k+1), with the low bound first. Mask bit j is set when live element j of B satisfies low <= B[j] <= high for at least one pair, using unsigned comparison. A pair counts only when both of its elements are live.
- R5: `mode_i`=3 (substring). Mask bit j is set when each live element k of A equals element j+k of B, and element j+k is live. Positions j+k that fall past the last element of the operand are treated as matching, so a substring cut off at the operand's end still reports a hit.
- R6: The live length of an operand is the index of its first zero element, or the element count if it has no zero element. Elements at or beyond that index are not live. In every mode, mask bit j is zero when j is at or beyond B's live length. With an empty A, substring mode sets exactly the live positions of B.
- R7: `index_o` is the position of the lowest set mask bit, and `not_found_o` is 0. When the mask is all zero, `not_found_o` is 1 and `index_o` equals the element count (16 or 8).
- R8: A request sampled with `valid_i` high at a rising edge shows its result on `mask_o`, `index_o` and `not_found_o` after that edge. `valid_o` is high for exactly the cycle after each sampled request.
- R9: While `valid_i` is low, `mask_o`, `index_o` and `not_found_o` keep their values, whatever the operand inputs do.
- R10: While `rst_ni` is low, `valid_o`, `mask_o`, `index_o` and `not_found_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| word_mode_i | input | 1 | 0: byte elements, 1: 16-bit elements |
| mode_i | input | 2 | Reduction: 0 equality, 1 membership, 2 ranges, 3 substring |
| src_a_i | input | 128 | Operand A (reference set, ranges or substring) |
| src_b_i | input | 128 | Operand B (string being examined) |
| valid_o | output | 1 | Result strobe |
| mask_o | output | 16 | Result mask, bit j for element j of B |
| index_o | output | 5 | Lowest set mask bit, or element count |
| not_found_o | output | 1 | Mask is all zero |

## Verification
In substring mode, a live element of B can end a candidate match early while the operand end cuts off a different candidate. Both of these act on a single result mask. The early end is the terminator forcing of R6, and the cut-off is the operand-end rule of R5.

Random strings drawn from a four-letter alphabet with sparse zero elements make both events common within one request. Directed vectors place a substring prefix in the last two positions of B and an empty A. Each mask is judged bit by bit against a bench model built from the requirements. The index and not-found outputs are judged on the same result, including the all-zero case in both element sizes.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [1:0] {
    MODE_EQ_EACH = 2'd0,
    MODE_EQ_ANY  = 2'd1,
    MODE_RANGES  = 2'd2,
    MODE_EQ_ORD  = 2'd3
  } psc_mode_e;
endpackage

// File: rtl/psc_unpack.sv
module psc_unpack #(
  parameter int OP_W   = 128,
  parameter int BYTE_W = 8,
  localparam int NE    = OP_W / BYTE_W,
  localparam int EW    = 2 * BYTE_W,
  localparam int NW    = NE / 2
) (
  input  logic [OP_W-1:0]        op_i,
  input  logic                   word_mode_i,
  output logic [NE-1:0][EW-1:0]  elem_o,
  output logic [NE-1:0]          live_o
);
  logic [NE-1:0] zero;

  for (genvar k = 0; k < NE; k++) begin : g_el
    logic [EW-1:0] b_e;
    logic [EW-1:0] w_e;
    assign b_e = {{BYTE_W{1'b0}}, op_i[k*BYTE_W +: BYTE_W]};
    if (k < NW) begin : g_w
      assign w_e = op_i[k*EW +: EW];
    end else begin : g_nw
      assign w_e = '0;
    end
    assign elem_o[k] = word_mode_i ? w_e : b_e;
    assign zero[k]   = (elem_o[k] == '0);
  end

  // live until first zero element; absent word slots read as zero
  always_comb begin
    logic run;
    run = 1'b1;
    for (int k = 0; k < NE; k++) begin
      run       = run & ~zero[k];
      live_o[k] = run;
    end
  end
endmodule

// File: rtl/psc_cmp_matrix.sv
module psc_cmp_matrix #(
  parameter int NE   = 16,
  parameter int EW   = 16,
  localparam int NP  = NE / 2
) (
  input  logic [NE-1:0][EW-1:0] a_i,
  input  logic [NE-1:0][EW-1:0] b_i,
  output logic [NE-1:0][NE-1:0] eq_o,     // [a row][b col]
  output logic [NP-1:0][NE-1:0] lo_ok_o,  // b >= low bound of pair
  output logic [NP-1:0][NE-1:0] hi_ok_o   // b <= high bound of pair
);
  for (genvar i = 0; i < NE; i++) begin : g_row
    for (genvar j = 0; j < NE; j++) begin : g_col
      assign eq_o[i][j] = (a_i[i] == b_i[j]);
    end
  end

  for (genvar k = 0; k < NP; k++) begin : g_pair
    for (genvar j = 0; j < NE; j++) begin : g_col
      assign lo_ok_o[k][j] = (b_i[j] >= a_i[2*k]);
      assign hi_ok_o[k][j] = (b_i[j] <= a_i[2*k+1]);
    end
  end
endmodule

// File: rtl/psc_aggregate.sv
module psc_aggregate
  import psc_pkg::*;
#(
  parameter int NE  = 16,
  localparam int NW = NE / 2,
  localparam int NP = NE / 2
) (
  input  psc_mode_e             mode_i,
  input  logic                  word_mode_i,
  input  logic [NE-1:0][NE-1:0] eq_i,
  input  logic [NP-1:0][NE-1:0] lo_ok_i,
  input  logic [NP-1:0][NE-1:0] hi_ok_i,
  input  logic [NE-1:0]         a_live_i,
  input  logic [NE-1:0]         b_live_i,
  output logic [NE-1:0]         mask_o
);
  logic [NE-1:0] m_each, m_any, m_rng, m_ord;

  for (genvar j = 0; j < NE; j++) begin : g_col
    logic [NE-1:0] col;
    logic [NP-1:0] pair_hit;
    logic [NE-1:0] ord_t;

    assign m_each[j] = eq_i[j][j] & a_live_i[j] & b_live_i[j];

    for (genvar i = 0; i < NE; i++) begin : g_any
      assign col[i] = eq_i[i][j] & a_live_i[i];
    end
    assign m_any[j] = b_live_i[j] & (|col);

    for (genvar k = 0; k < NP; k++) begin : g_rng
      assign pair_hit[k] = a_live_i[2*k+1] & lo_ok_i[k][j] & hi_ok_i[k][j];
    end
    assign m_rng[j] = b_live_i[j] & (|pair_hit);

    for (genvar k = 0; k < NE; k++) begin : g_ord
      if (j + k >= NE) begin : g_off
        assign ord_t[k] = 1'b1;
      end else if (j + k >= NW) begin : g_hi
        // word mode: slot beyond operand end counts as match
        assign ord_t[k] = ~a_live_i[k] | word_mode_i | (b_live_i[j+k] & eq_i[k][j+k]);
      end else begin : g_lo
        assign ord_t[k] = ~a_live_i[k] | (b_live_i[j+k] & eq_i[k][j+k]);
      end
    end
    assign m_ord[j] = b_live_i[j] & (&ord_t);
  end

  always_comb begin
    unique case (mode_i)
      MODE_EQ_EACH: mask_o = m_each;
      MODE_EQ_ANY:  mask_o = m_any;
      MODE_RANGES:  mask_o = m_rng;
      MODE_EQ_ORD:  mask_o = m_ord;
      default:      mask_o = '0;
    endcase
  end
endmodule

// File: rtl/psc_first_set.sv
module psc_first_set #(
  parameter int NE    = 16,
  parameter int IDX_W = 5
) (
  input  logic [NE-1:0]    mask_i,
  input  logic             word_mode_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             none_o
);
  always_comb begin
    idx_o = word_mode_i ? IDX_W'(NE / 2) : IDX_W'(NE);
    for (int k = NE - 1; k >= 0; k--) begin
      if (mask_i[k]) idx_o = IDX_W'(k);
    end
    none_o = ~|mask_i;
  end
endmodule

// File: rtl/pkd_str_cmp.sv
module pkd_str_cmp
  import psc_pkg::*;
#(
  parameter int OP_W    = 128,
  parameter int BYTE_W  = 8,
  localparam int NE     = OP_W / BYTE_W,
  localparam int EW     = 2 * BYTE_W,
  localparam int NP     = NE / 2,
  localparam int IDX_W  = $clog2(NE + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             word_mode_i,
  input  logic [1:0]       mode_i,
  input  logic [OP_W-1:0]  src_a_i,
  input  logic [OP_W-1:0]  src_b_i,
  output logic             valid_o,
  output logic [NE-1:0]    mask_o,
  output logic [IDX_W-1:0] index_o,
  output logic             not_found_o
);
  logic [NE-1:0][EW-1:0] a_el, b_el;
  logic [NE-1:0]         a_live, b_live;
  logic [NE-1:0][NE-1:0] eq;
  logic [NP-1:0][NE-1:0] lo_ok, hi_ok;
  logic [NE-1:0]         mask_d;
  logic [IDX_W-1:0]      idx_d;
  logic                  none_d;

  psc_unpack #(.OP_W(OP_W), .BYTE_W(BYTE_W)) u_unpack_a (
    .op_i(src_a_i), .word_mode_i(word_mode_i), .elem_o(a_el), .live_o(a_live)
  );

  psc_unpack #(.OP_W(OP_W), .BYTE_W(BYTE_W)) u_unpack_b (
    .op_i(src_b_i), .word_mode_i(word_mode_i), .elem_o(b_el), .live_o(b_live)
  );

  psc_cmp_matrix #(.NE(NE), .EW(EW)) u_matrix (
    .a_i(a_el), .b_i(b_el), .eq_o(eq), .lo_ok_o(lo_ok), .hi_ok_o(hi_ok)
  );

  psc_aggregate #(.NE(NE)) u_agg (
    .mode_i     (psc_mode_e'(mode_i)),
    .word_mode_i(word_mode_i),
    .eq_i       (eq),
    .lo_ok_i    (lo_ok),
    .hi_ok_i    (hi_ok),
    .a_live_i   (a_live),
    .b_live_i   (b_live),
    .mask_o     (mask_d)
  );

  psc_first_set #(.NE(NE), .IDX_W(IDX_W)) u_first (
    .mask_i(mask_d), .word_mode_i(word_mode_i), .idx_o(idx_d), .none_o(none_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      mask_o      <= '0;
      index_o     <= '0;
      not_found_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        mask_o      <= mask_d;
        index_o     <= idx_d;
        not_found_o <= none_d;
      end
    end
  end
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int NE    = 16,
  parameter int IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             word_mode_i,
  input logic             valid_o,
  input logic [NE-1:0]    mask_o,
  input logic [IDX_W-1:0] index_o,
  input logic             not_found_o
);
  logic cap_word;
  logic hit_at_idx;
  logic low_clear;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cap_word <= 1'b0;
    else if (valid_i) cap_word <= word_mode_i;
  end

  always_comb begin
    hit_at_idx = 1'b0;
    low_clear  = 1'b1;
    for (int k = 0; k < NE; k++) begin
      if (IDX_W'(k) == index_o) hit_at_idx = mask_o[k];
      if (IDX_W'(k) < index_o && mask_o[k]) low_clear = 1'b0;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R8
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(mask_o) && $stable(index_o) && $stable(not_found_o))); // R9
  AST_INDEX_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !not_found_o) |-> (hit_at_idx && low_clear)); // R7
  AST_NOT_FOUND_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && not_found_o) |->
      (mask_o == '0 && index_o == (cap_word ? IDX_W'(NE / 2) : IDX_W'(NE)))); // R7
  AST_WORD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cap_word) |-> (mask_o[NE-1:NE/2] == '0)); // R1
endmodule

bind pkd_str_cmp psc_checker #(.NE(NE), .IDX_W(IDX_W)) u_psc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .word_mode_i(word_mode_i),
  .valid_o    (valid_o),
  .mask_o     (mask_o),
  .index_o    (index_o),
  .not_found_o(not_found_o)
);

// File: tb/pkd_str_cmp_bench.sv
module pkd_str_cmp_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         word_mode_i = 1'b0;
  logic [1:0]   mode_i = 2'd0;
  logic [127:0] src_a_i = '0;
  logic [127:0] src_b_i = '0;
  logic         valid_o;
  logic [15:0]  mask_o;
  logic [4:0]   index_o;
  logic         not_found_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] last_mask = '0;

  always #10 clk_i = ~clk_i;

  pkd_str_cmp u_pkd_str_cmp (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] el(logic [127:0] op, bit w, int k);
    return w ? op[16*k +: 16] : {8'h00, op[8*k +: 8]};
  endfunction

  function automatic int live_len(logic [127:0] op, bit w);
    int n = w ? 8 : 16;
    int len = n;
    for (int k = n - 1; k >= 0; k--) if (el(op, w, k) == 16'h0) len = k;
    return len;
  endfunction

  function automatic logic [15:0] ref_mask(logic [127:0] a, logic [127:0] b, bit w, logic [1:0] m);
    int n = w ? 8 : 16;
    int la = live_len(a, w);
    int lb = live_len(b, w);
    logic [15:0] r = '0;
    for (int j = 0; j < n; j++) begin
      logic hit;
      hit = 1'b0;
      if (j < lb) begin
        case (m)
          2'd0: hit = (j < la) && (el(a, w, j) == el(b, w, j));
          2'd1: for (int i = 0; i < la; i++) if (el(a, w, i) == el(b, w, j)) hit = 1'b1;
          2'd2: for (int k = 0; 2*k + 1 < la; k++)
                  if (el(b, w, j) >= el(a, w, 2*k) && el(b, w, j) <= el(a, w, 2*k+1)) hit = 1'b1;
          default: begin
            hit = 1'b1;
            for (int k = 0; k < la && j + k < n; k++)
              if (j + k >= lb || el(a, w, k) != el(b, w, j + k)) hit = 1'b0;
          end
        endcase
      end
      r[j] = hit;
    end
    return r;
  endfunction

  function automatic logic [4:0] ref_idx(logic [15:0] msk, bit w);
    logic [4:0] r = w ? 5'd8 : 5'd16;
    for (int k = 15; k >= 0; k--) if (msk[k]) r = 5'(k);
    return r;
  endfunction

  function automatic logic [127:0] rand_op(bit w, logic [1:0] m);
    logic [127:0] r = '0;
    if (w) begin
      for (int k = 0; k < 8; k++) begin
        int s = int'($urandom % 12);
        logic [15:0] v;
        if (s == 0) v = 16'h0000;
        else if (m == 2'd2) v = 16'h0060 + 16'($urandom % 6);
        else v = (s > 9) ? 16'h0161 : 16'h0061 + 16'(s % 4);
        r[16*k +: 16] = v;
      end
    end else begin
      for (int k = 0; k < 16; k++) begin
        int s = int'($urandom % 24);
        logic [7:0] v;
        if (s == 0) v = 8'h00;
        else if (m == 2'd2) v = 8'h60 + 8'($urandom % 6);
        else v = 8'h61 + 8'(s % 4);
        r[8*k +: 8] = v;
      end
    end
    return r;
  endfunction

  task automatic run(logic [127:0] a, logic [127:0] b, bit w, logic [1:0] m, string tag);
    logic [15:0] em;
    em = ref_mask(a, b, w, m);
    @(negedge clk_i);
    src_a_i = a; src_b_i = b; word_mode_i = w; mode_i = m; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(tag, "mask", 32'(mask_o), 32'(em));
    chk("R7", "index", 32'(index_o), 32'(ref_idx(em, w)));
    chk("R7", "not_found", 32'(not_found_o), 32'(em == 16'h0));
    chk("R8", "valid_o", 32'(valid_o), 32'd1);
    last_mask = em;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    string tags[4];
    tags[0] = "R2"; tags[1] = "R3"; tags[2] = "R4"; tags[3] = "R5";
    void'($urandom(32'd1357));

    // R10 reset state
    repeat (3) @(negedge clk_i);
    chk("R10", "valid_o", 32'(valid_o), 0);
    chk("R10", "mask", 32'(mask_o), 0);
    chk("R10", "index", 32'(index_o), 0);
    chk("R10", "not_found", 32'(not_found_o), 0);
    rst_ni = 1'b1;

    // R2 identical strings, no terminator
    run(128'h706f6e6d6c6b6a696867666564636261, 128'h706f6e6d6c6b6a696867666564636261, 1'b0, 2'd0, "R2");
    // R7 nothing matches in byte mode
    run({16{8'h61}}, {16{8'h62}}, 1'b0, 2'd0, "R7");
    // R1 word mode no match: index = 8
    run({8{16'h0101}}, {8{16'h0202}}, 1'b1, 2'd1, "R1");
    // R1 word mode equality over words only
    run(128'h00080007000600050004000300020001, 128'h00080007000600050004000300020001, 1'b1, 2'd0, "R1");
    // R5 substring cut off at operand end
    run(128'h0000000000000000000000000000007a7978, 128'h79787171717171717171717171717171, 1'b0, 2'd3, "R5");
    // R6 empty A in substring mode sets live B positions
    run(128'h0, 128'h00000000000000000000000000636261, 1'b0, 2'd3, "R6");
    // R6 A elements past terminator ignored in membership
    run(128'h00000000000000000000000063006261, {16{8'h63}}, 1'b0, 2'd1, "R6");
    // R4 pair straddling A's terminator is not used
    run(128'h00000000000000000000000000786361, 128'h000000000000000000000000007a7862, 1'b0, 2'd2, "R4");

    // R9 hold while valid_i low, inputs changing
    @(negedge clk_i);
    src_a_i = {16{8'h41}}; src_b_i = {16{8'h41}}; mode_i = 2'd0; word_mode_i = 1'b0;
    @(negedge clk_i);
    chk("R9", "mask hold", 32'(mask_o), 32'(last_mask));
    chk("R8", "valid_o idle", 32'(valid_o), 0);

    for (int it = 0; it < 600; it++) begin
      bit w = 1'($urandom % 2);
      logic [1:0] m = 2'($urandom % 4);
      logic [127:0] a = rand_op(w, m);
      logic [127:0] b = rand_op(w, m);
      if (m == 2'd3 && ($urandom % 3) == 0) begin
        // plant a prefix of B as the substring to force hits
        int sh = int'($urandom % 8);
        a = w ? (b >> (16 * sh)) : (b >> (8 * sh));
        if (w) a[127:48] = '0; else a[127:24] = '0;
      end
      run(a, b, w, m, tags[m]);
    end

    done = 1'b1;
    summary();
  end
endmodule